// File: doc/BRIEF.md
# Reset configuration word loader

This block obtains the 32-bit hard reset configuration word of a device once power-on reset is released. While reset is held, two mode pins are captured continuously. The value present at the last clock edge of reset decides the role for the rest of the session, and later changes on those pins have no effect.

In the master role the block reads a boot PROM through a byte-wide request/valid port. Its own word is assembled from four bytes spaced eight addresses apart. It then serves a programmable number of downstream devices, from none to seven. For each one it gathers another four-byte group from the next 32-byte window, asserts that device's select line and a shared hard reset line, and drives the assembled word on a data bus for one write-strobe cycle. In either slave role the block issues no PROM traffic and waits for a host to write the word. If no write arrives within a fixed window, it settles on an all-zero word. The reserved mode settles on the all-zero word at once.

Top module: `rcw_loader`

## Requirements
- R1: `cfg_mode_i` and `slave_cnt_i` are captured on every clock edge while `rst` is high and held afterwards. Changing them after reset is released has no effect on the sequence.
- R2: In master mode (`cfg_mode_i` = 2'b00) the local word is built from PROM bytes at addresses 0x00, 0x08, 0x10 and 0x18. The byte at 0x00 becomes bits 31:24 and the byte at 0x18 becomes bits 7:0. The result appears on `cfg_word_o`.
- R3: After the local word, the master reads exactly `slave_cnt_i` further groups. Group k (1 to 7) comes from addresses 32*k, 32*k+8, 32*k+16 and 32*k+24, in that order. A count of 0 ends the sequence after the local word.
- R4: During the reads and the write of group k, `sel_o` equals 1 << (k-1) and `slv_rst_o` is high. At all other times both are zero, and `sel_o` never has more than one bit set.
- R5: After each group k has been read, `bus_wr_o` is high for exactly one cycle while `bus_data_o` carries that group's assembled word, most significant byte first.
- R6: While `rd_req_o` is high and `rd_valid_i` is low, `rd_req_o` and `rd_addr_o` hold their values. Any number of wait cycles is tolerated.
- R7: In the slave modes (2'b01 and 2'b10), a `host_wr_i` sampled on clock edges 2 to 1025 after reset release is accepted, counting the first edge with `rst` low as edge 1. `cfg_word_o` takes `host_data_i`, and `done_o` is high after the following edge.
- R8: In the slave modes, if no write is accepted, `cfg_word_o` is 0 and `done_o` is high after edge 1026. A write on edge 1026 or later is ignored.
- R9: In the reserved mode (2'b11), `done_o` is high after edge 1, `cfg_word_o` is 0, and no PROM read is issued.
- R10: In the slave and reserved modes `rd_req_o` never goes high.
- R11: `done_o` is high for exactly one cycle per reset. From then on `cfg_word_o` holds its value until the next reset, whatever happens on `host_wr_i`.
- R12: While `rst` is high, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| cfg_mode_i | input | 2 | Role select pins, captured during reset |
| slave_cnt_i | input | 3 | Number of downstream devices to configure (0 to 7), captured during reset |
| rd_req_o | output | 1 | PROM byte read request, held until accepted |
| rd_addr_o | output | 8 | PROM byte address |
| rd_valid_i | input | 1 | PROM read data valid; completes the pending request |
| rd_data_i | input | 8 | PROM read data byte |
| host_wr_i | input | 1 | Host write strobe for the word (slave modes) |
| host_data_i | input | 32 | Host-written configuration word |
| sel_o | output | 7 | One-hot select of the downstream device being configured |
| slv_rst_o | output | 1 | Hard reset held on the downstream device during its transfer |
| bus_wr_o | output | 1 | Write-direction strobe for the configuration write |
| bus_data_o | output | 32 | Configuration word driven to the selected device |
| cfg_word_o | output | 32 | Latched local configuration word |
| done_o | output | 1 | One-cycle pulse when configuration is finished |

## Verification
The assertions assume that the PROM raises `rd_valid_i` only for a pending request and for a single cycle per byte. They also assume that the host strobe is meaningful only while the block waits in a slave role. The bench's PROM model keeps to this by answering each pending address once after a chosen latency and lowering valid in the next cycle. Host strobes are placed at chosen edges, including the first and last accepted edge of the window and the first edge past it. Mode and count pins are changed only after reset has been released, to show that they are ignored.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_GATHER,
    ST_WRITE,
    ST_WAIT,
    ST_DONE
  } seq_state_t;

  localparam logic [1:0] MODE_MASTER   = 2'b00;
  localparam logic [1:0] MODE_SLV_BUS  = 2'b01;
  localparam logic [1:0] MODE_SLV_THRU = 2'b10;
  localparam logic [1:0] MODE_RSVD     = 2'b11;
endpackage

// File: rtl/rcw_byte_gather.sv
module rcw_byte_gather #(
  parameter int AW          = 8,
  parameter int NBYTES      = 4,
  parameter int BYTE_STRIDE = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [AW-1:0]         base_i,
  input  logic                  rd_valid_i,
  input  logic [7:0]            rd_data_i,
  output logic                  rd_req_o,
  output logic [AW-1:0]         rd_addr_o,
  output logic [8*NBYTES-1:0]   word_o,
  output logic                  grp_done_o
);
  localparam int WW = 8 * NBYTES;
  localparam int BW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [BW-1:0] byt_q;
  logic [WW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_o   <= 1'b0;
      rd_addr_o  <= '0;
      byt_q      <= '0;
      acc_q      <= '0;
      grp_done_o <= 1'b0;
    end else begin
      grp_done_o <= 1'b0;
      if (start_i && !rd_req_o) begin
        rd_req_o  <= 1'b1;
        rd_addr_o <= base_i;
        byt_q     <= '0;
      end else if (rd_req_o && rd_valid_i) begin
        acc_q <= {acc_q[WW-9:0], rd_data_i};
        if (byt_q == BW'(NBYTES - 1)) begin
          rd_req_o   <= 1'b0;
          grp_done_o <= 1'b1;
        end else begin
          byt_q     <= byt_q + 1'b1;
          rd_addr_o <= rd_addr_o + AW'(BYTE_STRIDE);
        end
      end
    end
  end

  assign word_o = acc_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o))); // R6

  AST_STEP_STRIDE: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_valid_i && rd_req_o && !grp_done_o && byt_q != BW'(NBYTES - 1))
      |=> (rd_addr_o == $past(rd_addr_o) + AW'(BYTE_STRIDE))); // R2
endmodule

// File: rtl/rcw_host_wait.sv
module rcw_host_wait #(
  parameter int WW      = 32,
  parameter int TIMEOUT = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_i,
  input  logic          wr_en_i,
  input  logic [WW-1:0] wr_data_i,
  output logic          fin_o,
  output logic [WW-1:0] word_o
);
  localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic [TW-1:0] timer_q;
  logic          fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q <= '0;
      fired_q <= 1'b0;
      fin_o   <= 1'b0;
      word_o  <= '0;
    end else begin
      fin_o <= 1'b0;
      if (arm_i && !fired_q) begin
        if (wr_en_i) begin
          word_o  <= wr_data_i;
          fin_o   <= 1'b1;
          fired_q <= 1'b1;
        end else if (timer_q == TW'(TIMEOUT - 1)) begin
          word_o  <= '0;
          fin_o   <= 1'b1;
          fired_q <= 1'b1;
        end else begin
          timer_q <= timer_q + 1'b1;
        end
      end
    end
  end

  AST_TIMEOUT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($rose(fin_o) && !$past(wr_en_i)) |-> (word_o == '0)); // R8

  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> !fin_o); // R11
endmodule

// File: rtl/rcw_loader.sv
module rcw_loader
  import rcw_pkg::*;
#(
  parameter int AW           = 8,
  parameter int SLV_MAX      = 7,
  parameter int TIMEOUT      = 1024,
  parameter int BYTE_STRIDE  = 8,
  parameter int GROUP_STRIDE = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   cfg_mode_i,
  input  logic [$clog2(SLV_MAX+1)-1:0] slave_cnt_i,
  output logic                         rd_req_o,
  output logic [AW-1:0]                rd_addr_o,
  input  logic                         rd_valid_i,
  input  logic [7:0]                   rd_data_i,
  input  logic                         host_wr_i,
  input  logic [31:0]                  host_data_i,
  output logic [SLV_MAX-1:0]           sel_o,
  output logic                         slv_rst_o,
  output logic                         bus_wr_o,
  output logic [31:0]                  bus_data_o,
  output logic [31:0]                  cfg_word_o,
  output logic                         done_o
);
  localparam int CW = $clog2(SLV_MAX + 1);
  localparam int WW = 32;

  seq_state_t     state_q;
  logic [1:0]     mode_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  grp_q;
  logic           gstart_q;
  logic [AW-1:0]  gbase_q;
  logic [WW-1:0]  gword;
  logic           gdone;
  logic           hfin;
  logic [WW-1:0]  hword;
  logic           arm;

  assign arm = (state_q == ST_WAIT);

  rcw_byte_gather #(
    .AW(AW), .NBYTES(WW / 8), .BYTE_STRIDE(BYTE_STRIDE)
  ) i_gather (
    .clk(clk), .rst(rst), .start_i(gstart_q), .base_i(gbase_q),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .word_o(gword), .grp_done_o(gdone)
  );

  rcw_host_wait #(
    .WW(WW), .TIMEOUT(TIMEOUT)
  ) i_wait (
    .clk(clk), .rst(rst), .arm_i(arm), .wr_en_i(host_wr_i),
    .wr_data_i(host_data_i), .fin_o(hfin), .word_o(hword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_START;
      mode_q     <= cfg_mode_i;
      cnt_q      <= slave_cnt_i;
      grp_q      <= '0;
      gstart_q   <= 1'b0;
      gbase_q    <= '0;
      sel_o      <= '0;
      slv_rst_o  <= 1'b0;
      bus_wr_o   <= 1'b0;
      bus_data_o <= '0;
      cfg_word_o <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      gstart_q <= 1'b0;
      case (state_q)
        ST_START: begin
          case (mode_q)
            MODE_MASTER: begin
              gstart_q <= 1'b1;
              gbase_q  <= '0;
              grp_q    <= '0;
              state_q  <= ST_GATHER;
            end
            MODE_SLV_BUS, MODE_SLV_THRU: state_q <= ST_WAIT;
            default: begin
              cfg_word_o <= '0;
              done_o     <= 1'b1;
              state_q    <= ST_DONE;
            end
          endcase
        end
        ST_GATHER: begin
          if (gdone) begin
            if (grp_q == '0) begin
              cfg_word_o <= gword;
              if (cnt_q == '0) begin
                done_o  <= 1'b1;
                state_q <= ST_DONE;
              end else begin
                grp_q     <= grp_q + 1'b1;
                gbase_q   <= gbase_q + AW'(GROUP_STRIDE);
                gstart_q  <= 1'b1;
                sel_o     <= {{(SLV_MAX-1){1'b0}}, 1'b1};
                slv_rst_o <= 1'b1;
              end
            end else begin
              bus_data_o <= gword;
              bus_wr_o   <= 1'b1;
              state_q    <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          bus_wr_o <= 1'b0;
          if (grp_q == cnt_q) begin
            sel_o     <= '0;
            slv_rst_o <= 1'b0;
            done_o    <= 1'b1;
            state_q   <= ST_DONE;
          end else begin
            grp_q    <= grp_q + 1'b1;
            gbase_q  <= gbase_q + AW'(GROUP_STRIDE);
            gstart_q <= 1'b1;
            sel_o    <= sel_o << 1;
            state_q  <= ST_GATHER;
          end
        end
        ST_WAIT: begin
          if (hfin) begin
            cfg_word_o <= hword;
            done_o     <= 1'b1;
            state_q    <= ST_DONE;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o)); // R4

  AST_WR_SELECTED: assert property (@(posedge clk) disable iff (rst)
    bus_wr_o |-> (sel_o != '0 && slv_rst_o)); // R4

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_wr_o |=> !bus_wr_o); // R5

  AST_NO_PROM_SLAVE: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_MASTER) |-> !rd_req_o); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R11

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE && !done_o) |-> $stable(cfg_word_o)); // R11

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && mode_q == MODE_RSVD) |=> (done_o && cfg_word_o == '0)); // R9
endmodule

// File: tb/test_rcw_loader.sv
module test_rcw_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode_i = 2'b00;
  logic [2:0]  slave_cnt_i = 3'd0;
  logic        rd_req_o;
  logic [7:0]  rd_addr_o;
  logic        rd_valid_i = 1'b0;
  logic [7:0]  rd_data_i = 8'h00;
  logic        host_wr_i = 1'b0;
  logic [31:0] host_data_i = 32'h0;
  logic [6:0]  sel_o;
  logic        slv_rst_o;
  logic        bus_wr_o;
  logic [31:0] bus_data_o;
  logic [31:0] cfg_word_o;
  logic        done_o;

  rcw_loader i_rcw_loader (
    .clk(clk), .rst(rst), .cfg_mode_i(cfg_mode_i), .slave_cnt_i(slave_cnt_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .host_wr_i(host_wr_i), .host_data_i(host_data_i),
    .sel_o(sel_o), .slv_rst_o(slv_rst_o), .bus_wr_o(bus_wr_o),
    .bus_data_o(bus_data_o), .cfg_word_o(cfg_word_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int total = 0;
  int seed = 0;
  int lat = 0;
  int wcnt = 0;
  int rd_idx = 0;
  int wr_idx = 0;
  int done_cnt = 0;
  int done_cyc = -1;
  int mgrp;
  logic [6:0] msel;
  int          exp_addr[$];
  logic [31:0] exp_wdata[$];
  logic [6:0]  exp_wsel[$];

  function automatic logic [7:0] prom(input int a);
    return 8'((a * 37 + seed) & 255);
  endfunction

  function automatic logic [31:0] grp_word(input int s);
    return {prom(s*32), prom(s*32 + 8), prom(s*32 + 16), prom(s*32 + 24)};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
    total <= total + 1;
    if (total > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", total, 150000);
      summary();
      $finish;
    end
  end

  // Behavioural PROM and per-clock comparison against the expected sequence
  always @(negedge clk) begin
    rd_valid_i = 1'b0;
    if (!rst) begin
      if (rd_req_o) begin
        if (rd_idx >= exp_addr.size()) begin
          chk(1'b0, "R10", "read beyond expected sequence", 32'(rd_addr_o), 32'hFFFF_FFFF);
        end else begin
          mgrp = rd_idx / 4;
          msel = (mgrp == 0) ? 7'd0 : 7'(1 << (mgrp - 1));
          chk(32'(rd_addr_o) == exp_addr[rd_idx], "R6", "pending read address",
              32'(rd_addr_o), exp_addr[rd_idx]);
          chk(sel_o == msel && slv_rst_o == (mgrp != 0), "R4", "select during read",
              {24'h0, slv_rst_o, sel_o}, {24'h0, mgrp != 0, msel});
          if (wcnt >= lat) begin
            rd_data_i  = prom(32'(rd_addr_o));
            rd_valid_i = 1'b1;
            wcnt = 0;
            rd_idx++;
          end else begin
            wcnt++;
          end
        end
      end
      if (bus_wr_o) begin
        if (wr_idx >= exp_wdata.size()) begin
          chk(1'b0, "R5", "unexpected write", bus_data_o, 32'h0);
        end else begin
          chk(bus_data_o == exp_wdata[wr_idx], "R5", "write data", bus_data_o, exp_wdata[wr_idx]);
          chk(sel_o == exp_wsel[wr_idx] && slv_rst_o, "R4", "select during write",
              {24'h0, slv_rst_o, sel_o}, {24'h0, 1'b1, exp_wsel[wr_idx]});
        end
        wr_idx++;
      end
      if (done_o) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic do_reset(input logic [1:0] m, input int n);
    rst = 1'b1;
    cfg_mode_i = m;
    slave_cnt_i = 3'(n);
    host_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rd_req_o && !bus_wr_o && !done_o && sel_o == 0 && !slv_rst_o && cfg_word_o == 0,
        "R12", "outputs during reset", cfg_word_o, 32'h0);
    rd_idx = 0; wr_idx = 0; done_cnt = 0; done_cyc = -1; wcnt = 0;
    rst = 1'b0;
  endtask

  task automatic post_done_hold(input string tag);
    logic [31:0] held;
    held = cfg_word_o;
    host_data_i = 32'h5A5A_0F0F;
    host_wr_i = 1'b1;
    repeat (3) @(negedge clk);
    host_wr_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(cfg_word_o == held && done_cnt == 1, tag, "word held after done", cfg_word_o, held);
  endtask

  task automatic run_master(input int n, input int l, input int sd);
    int guard;
    seed = sd; lat = l;
    exp_addr.delete(); exp_wdata.delete(); exp_wsel.delete();
    for (int s = 0; s <= n; s++)
      for (int b = 0; b < 4; b++) exp_addr.push_back(s*32 + b*8);
    for (int s = 1; s <= n; s++) begin
      exp_wdata.push_back(grp_word(s));
      exp_wsel.push_back(7'(1 << (s - 1)));
    end
    do_reset(2'b00, n);
    @(negedge clk);
    cfg_mode_i = 2'b11;  // R1: ignored after release
    slave_cnt_i = 3'd0;
    guard = 0;
    while (done_cnt == 0 && guard < 3000) begin @(negedge clk); guard++; end
    repeat (5) @(negedge clk);
    chk(rd_idx > 0 && done_cnt == 1, "R1", "late pin change ignored", rd_idx, 4*(n+1));
    chk(done_cnt == 1, "R11", "single done pulse", done_cnt, 1);
    chk(cfg_word_o == grp_word(0), "R2", "local word", cfg_word_o, grp_word(0));
    chk(rd_idx == 4*(n+1), "R3", "read count", rd_idx, 4*(n+1));
    chk(wr_idx == n, "R5", "write count", wr_idx, n);
    chk(sel_o == 0 && !slv_rst_o, "R4", "select released", {24'h0, slv_rst_o, sel_o}, 32'h0);
    post_done_hold("R11");
  endtask

  task automatic run_slave(input logic [1:0] m, input int k, input logic [31:0] data);
    int exp_cyc;
    logic [31:0] exp_word;
    exp_addr.delete(); exp_wdata.delete(); exp_wsel.delete();
    do_reset(m, 0);
    host_data_i = data;
    if (k > 0) begin
      while (cyc != k - 1) @(negedge clk);
      host_wr_i = 1'b1;
      @(negedge clk);
      host_wr_i = 1'b0;
    end
    while (cyc < 1030) @(negedge clk);
    if (k >= 2 && k <= 1025) begin
      exp_cyc = k + 1; exp_word = data;
      chk(done_cyc == exp_cyc, "R7", "done edge after host write", done_cyc, exp_cyc);
      chk(cfg_word_o == exp_word, "R7", "host word taken", cfg_word_o, exp_word);
    end else begin
      exp_cyc = 1026; exp_word = 32'h0;
      chk(done_cyc == exp_cyc, "R8", "timeout done edge", done_cyc, exp_cyc);
      chk(cfg_word_o == exp_word, "R8", "timeout default word", cfg_word_o, exp_word);
    end
    chk(done_cnt == 1, "R11", "single done pulse", done_cnt, 1);
    chk(rd_idx == 0, "R10", "no PROM read in slave mode", rd_idx, 0);
    post_done_hold("R11");
  endtask

  initial begin
    run_master(0, 0, 5);
    run_master(3, 2, 17);
    run_master(7, 0, 99);
    run_master(2, 3, 41);
    run_slave(2'b01, 40, 32'hA5A5_1234);
    run_slave(2'b10, 1025, 32'hC0FF_EE01);
    run_slave(2'b01, 1026, 32'h1357_9BDF);
    run_slave(2'b10, 0, 32'hFFFF_FFFF);
    exp_addr.delete();
    do_reset(2'b11, 5);
    repeat (10) @(negedge clk);
    chk(done_cyc == 1, "R9", "reserved mode done edge", done_cyc, 1);
    chk(cfg_word_o == 0, "R9", "reserved mode word", cfg_word_o, 32'h0);
    chk(rd_idx == 0, "R10", "no PROM read in reserved mode", rd_idx, 0);
    summary();
    $finish;
  end
endmodule